// File: doc/BRIEF.md
# Effective Address Decoder (32-bit)

This block turns the addressing bytes of an x86-style memory operand into a 32-bit effective offset. It takes a byte-serial instruction stream over a valid/ready handshake. The first byte is the addressing byte. It is followed by an optional scale/index/base byte and then by zero, one or four displacement bytes. The block works out from the bytes already received how many more bytes it needs, and it takes exactly that many.

Base and index values come from an external eight-entry general register file. That file is read combinationally through two select outputs. When the last byte has been accepted, the block raises `done_o` for one cycle. In that cycle it presents the offset, the number of bytes consumed (1 to 6) and an invalid-encoding flag. It then returns to waiting for the next addressing byte. All arithmetic wraps modulo 2^32.

Register codes 0..7 name eax, ecx, edx, ebx, esp, ebp, esi and edi, in that order.

Top module: `ea_decoder32`

## Requirements
- R1: Addressing byte fields are mod = bits 7:6 and rm = bits 2:0; bits 5:3 are ignored. With mod 0 and rm other than 4 or 5, the offset is the register selected by rm, the length is 1 and invalid is 0.
- R2: With mod 1 and rm other than 4, one displacement byte follows. It is sign-extended and added to the register selected by rm, and the length is 2.
- R3: With mod 2 and rm other than 4, four displacement bytes follow, least significant byte first. They are added to the register selected by rm, and the length is 5.
- R4: With mod 0 and rm 5, the offset is the four-byte displacement alone, with no register added, and the length is 5.
- R5: When rm is 4 and mod is not 3, a second byte follows with scale = bits 7:6, index = bits 5:3 and base = bits 2:0. The offset is base register + (index register << scale) + displacement, with the displacement sized by mod as in R2/R3 (none for mod 0). The length is 2, 3 or 6.
- R6: With mod 0 and a second-byte base of 5, no base register is added and a four-byte displacement follows (length 6).
- R7: An index code of 4 adds no index. If the scale is nonzero with index 4, invalid is 1; otherwise invalid stays 0 for every encoding with mod not 3.
- R8: mod 3 is illegal. After the single addressing byte the block completes with invalid 1, length 1 and offset 0.
- R9: Every sum wraps modulo 2^32.
- R10: After reset, ready is 1 and done is 0. done is high for exactly one cycle, ready is low during that cycle, and ready is high again in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_valid_i | input | 1 | Stream byte valid |
| byte_data_i | input | 8 | Stream byte |
| byte_ready_o | output | 1 | Block accepts a byte this cycle |
| base_sel_o | output | 3 | Register file read select for the base |
| base_val_i | input | 32 | Register value for base_sel_o |
| idx_sel_o | output | 3 | Register file read select for the index |
| idx_val_i | input | 32 | Register value for idx_sel_o |
| done_o | output | 1 | One-cycle completion strobe |
| offset_o | output | 32 | Effective offset, valid with done_o |
| len_o | output | 3 | Bytes consumed, valid with done_o |
| invalid_o | output | 1 | Illegal encoding, valid with done_o |

## Verification
Directed encodings cover each addressing form once:
- a plain register;
- negative and positive byte displacements, which separate sign extension from zero extension;
- a four-byte displacement, which exposes byte order;
- the no-base and no-index escapes;
- esp as a base, which distinguishes the base path from the no-index code;
- the illegal scale and mod 3 cases;
- a register near 2^32, which checks the wrap.

Random bytes are then drawn for all fields, with fresh register contents per instruction and idle gaps between bytes. A predicted length that differs from the consumed count shows up as a stream desynchronised from the model.

// File: rtl/ea_pkg.sv
package ea_pkg;
  localparam int EA_W     = 32;
  localparam int REG_N    = 8;
  localparam int SEL_W    = $clog2(REG_N);
  localparam int DISP_NB  = EA_W / 8;
  localparam int CNT_W    = $clog2(DISP_NB + 1);
  localparam int LEN_W    = $clog2(DISP_NB + 3);
  localparam int LEN_MAX  = DISP_NB + 2;
  localparam logic [SEL_W-1:0] CODE_NOIDX = SEL_W'(4);
  localparam logic [SEL_W-1:0] CODE_NOBASE = SEL_W'(5);

  typedef enum logic [1:0] {
    ST_MODRM,
    ST_SIB,
    ST_DISP,
    ST_DONE
  } ea_state_e;

  typedef struct packed {
    logic             base_en;
    logic [SEL_W-1:0] base;
    logic             idx_en;
    logic [SEL_W-1:0] idx;
    logic [1:0]       scale;
    logic [CNT_W-1:0] disp_nb;
    logic             disp_sext;
    logic             bad;
  } ea_form_t;
endpackage

// File: rtl/ea_modrm_dec.sv
module ea_modrm_dec
  import ea_pkg::*;
(
  input  logic [1:0]       mod_i,
  input  logic [SEL_W-1:0] rm_i,
  output ea_form_t         form_o,
  output logic             need_sib_o
);
  always_comb begin
    form_o           = '0;
    form_o.base      = rm_i;
    form_o.base_en   = 1'b1;
    form_o.idx       = CODE_NOIDX;
    need_sib_o       = (mod_i != 2'd3) && (rm_i == CODE_NOIDX);
    unique case (mod_i)
      2'd0: if (rm_i == CODE_NOBASE) begin
              form_o.base_en = 1'b0;
              form_o.disp_nb = CNT_W'(DISP_NB);
            end
      2'd1: begin
              form_o.disp_nb   = CNT_W'(1);
              form_o.disp_sext = 1'b1;
            end
      2'd2: form_o.disp_nb = CNT_W'(DISP_NB);
      default: begin
              form_o.base_en = 1'b0;
              form_o.bad     = 1'b1;
            end
    endcase
  end
endmodule

// File: rtl/ea_sib_dec.sv
module ea_sib_dec
  import ea_pkg::*;
(
  input  logic [1:0] mod_i,
  input  logic [7:0] sib_i,
  output ea_form_t   form_o
);
  logic [SEL_W-1:0] base, idx;
  logic [1:0]       scale;
  assign scale = sib_i[7:6];
  assign idx   = sib_i[5:3];
  assign base  = sib_i[2:0];

  always_comb begin
    form_o         = '0;
    form_o.base    = base;
    form_o.idx     = idx;
    form_o.scale   = scale;
    form_o.base_en = !((mod_i == 2'd0) && (base == CODE_NOBASE));
    form_o.idx_en  = (idx != CODE_NOIDX);
    form_o.bad     = (idx == CODE_NOIDX) && (scale != 2'd0);
    if (mod_i == 2'd1) begin
      form_o.disp_nb   = CNT_W'(1);
      form_o.disp_sext = 1'b1;
    end else if ((mod_i == 2'd2) || !form_o.base_en) begin
      form_o.disp_nb = CNT_W'(DISP_NB);
    end
  end
endmodule

// File: rtl/ea_disp_acc.sv
module ea_disp_acc #(
  parameter int W     = 32,
  parameter int NB    = W / 8,
  parameter int POS_W = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             we_i,
  input  logic [POS_W-1:0] pos_i,
  input  logic [7:0]       byte_i,
  input  logic             sext_i,
  output logic [W-1:0]     disp_o
);
  logic [NB-1:0][7:0] lane_q;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               lane_q[g] <= '0;
      else if (clr_i)                            lane_q[g] <= '0;
      else if (we_i && (pos_i == POS_W'(g)))     lane_q[g] <= byte_i;
    end
  end

  assign disp_o = sext_i ? {{(W-8){lane_q[0][7]}}, lane_q[0]} : lane_q;
endmodule

// File: rtl/ea_agu.sv
module ea_agu #(
  parameter int W = 32
) (
  input  logic         base_en_i,
  input  logic [W-1:0] base_i,
  input  logic         idx_en_i,
  input  logic [W-1:0] idx_i,
  input  logic [1:0]   scale_i,
  input  logic [W-1:0] disp_i,
  output logic [W-1:0] sum_o
);
  logic [W-1:0] base_term, idx_term;
  assign base_term = base_en_i ? base_i : '0;
  assign idx_term  = idx_en_i ? (idx_i << scale_i) : '0;
  assign sum_o     = base_term + idx_term + disp_i;
endmodule

// File: rtl/ea_decoder32.sv
module ea_decoder32
  import ea_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             byte_valid_i,
  input  logic [7:0]       byte_data_i,
  output logic             byte_ready_o,
  output logic [SEL_W-1:0] base_sel_o,
  input  logic [EA_W-1:0]  base_val_i,
  output logic [SEL_W-1:0] idx_sel_o,
  input  logic [EA_W-1:0]  idx_val_i,
  output logic             done_o,
  output logic [EA_W-1:0]  offset_o,
  output logic [LEN_W-1:0] len_o,
  output logic             invalid_o
);
  localparam int POS_W = (DISP_NB > 1) ? $clog2(DISP_NB) : 1;

  ea_state_e        state_q;
  ea_form_t         form_q, mdec_form, sdec_form;
  logic             mdec_sib;
  logic [1:0]       mod_q;
  logic [LEN_W-1:0] len_q;
  logic [POS_W-1:0] pos_q;
  logic [CNT_W-1:0] left_q;
  logic [EA_W-1:0]  disp;
  logic             accept;

  assign byte_ready_o = (state_q != ST_DONE);
  assign accept       = byte_valid_i && byte_ready_o;

  ea_modrm_dec u_modrm (
    .mod_i      (byte_data_i[7:6]),
    .rm_i       (byte_data_i[2:0]),
    .form_o     (mdec_form),
    .need_sib_o (mdec_sib)
  );

  ea_sib_dec u_sib (
    .mod_i  (mod_q),
    .sib_i  (byte_data_i),
    .form_o (sdec_form)
  );

  ea_disp_acc #(.W(EA_W), .NB(DISP_NB), .POS_W(POS_W)) u_disp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (accept && (state_q == ST_MODRM)),
    .we_i   (accept && (state_q == ST_DISP)),
    .pos_i  (pos_q),
    .byte_i (byte_data_i),
    .sext_i (form_q.disp_sext),
    .disp_o (disp)
  );

  ea_agu #(.W(EA_W)) u_agu (
    .base_en_i (form_q.base_en),
    .base_i    (base_val_i),
    .idx_en_i  (form_q.idx_en),
    .idx_i     (idx_val_i),
    .scale_i   (form_q.scale),
    .disp_i    (disp),
    .sum_o     (offset_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_MODRM;
      form_q  <= '0;
      mod_q   <= '0;
      len_q   <= '0;
      pos_q   <= '0;
      left_q  <= '0;
    end else begin
      unique case (state_q)
        ST_MODRM: if (accept) begin
          form_q <= mdec_form;
          mod_q  <= byte_data_i[7:6];
          len_q  <= LEN_W'(1);
          pos_q  <= '0;
          left_q <= mdec_form.disp_nb;
          if (mdec_form.bad)                state_q <= ST_DONE;
          else if (mdec_sib)                state_q <= ST_SIB;
          else if (mdec_form.disp_nb != 0)  state_q <= ST_DISP;
          else                              state_q <= ST_DONE;
        end
        ST_SIB: if (accept) begin
          form_q  <= sdec_form;
          len_q   <= len_q + LEN_W'(1);
          left_q  <= sdec_form.disp_nb;
          state_q <= (sdec_form.disp_nb != 0) ? ST_DISP : ST_DONE;
        end
        ST_DISP: if (accept) begin
          len_q  <= len_q + LEN_W'(1);
          pos_q  <= pos_q + POS_W'(1);
          left_q <= left_q - CNT_W'(1);
          if (left_q == CNT_W'(1)) state_q <= ST_DONE;
        end
        default: state_q <= ST_MODRM;
      endcase
    end
  end

  assign base_sel_o = form_q.base;
  assign idx_sel_o  = form_q.idx;
  assign done_o     = (state_q == ST_DONE);
  assign len_o      = len_q;
  assign invalid_o  = form_q.bad;
endmodule

// File: rtl/ea_decoder32_chk.sv
module ea_decoder32_chk
  import ea_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             byte_ready_o,
  input logic             done_o,
  input logic [EA_W-1:0]  offset_o,
  input logic [LEN_W-1:0] len_o,
  input logic             invalid_o
);
  AST_DONE_BLOCKS_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !byte_ready_o); // R10
  AST_DONE_SINGLE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && byte_ready_o)); // R10
  AST_LEN_BOUNDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (len_o >= LEN_W'(1) && len_o <= LEN_W'(LEN_MAX))); // R5
  AST_MOD3_ZERO_OFFSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && invalid_o && len_o == LEN_W'(1)) |-> (offset_o == '0)); // R8
endmodule

bind ea_decoder32 ea_decoder32_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .byte_ready_o (byte_ready_o),
  .done_o       (done_o),
  .offset_o     (offset_o),
  .len_o        (len_o),
  .invalid_o    (invalid_o)
);

// File: tb/ea_decoder32_tb.sv
module ea_decoder32_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vld = 1'b0;
  logic [7:0]  dat = '0;
  logic        rdy, done, inv;
  logic [2:0]  bsel, isel, len;
  logic [31:0] bval, ival, off;
  logic [31:0] regs [8];
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  assign bval = regs[bsel];
  assign ival = regs[isel];

  ea_decoder32 u_dut (
    .clk_i(clk), .rst_ni(rst_n), .byte_valid_i(vld), .byte_data_i(dat),
    .byte_ready_o(rdy), .base_sel_o(bsel), .base_val_i(bval),
    .idx_sel_o(isel), .idx_val_i(ival), .done_o(done), .offset_o(off),
    .len_o(len), .invalid_o(inv)
  );

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  function automatic string req_of(input logic [47:0] s);
    logic [1:0] md = s[7:6];
    logic [2:0] rm = s[2:0];
    if (md == 2'd3) return "R8";
    if (rm == 3'd4) begin
      if (s[13:11] == 3'd4 && s[15:14] != 2'd0) return "R7";
      if (md == 2'd0 && s[10:8] == 3'd5) return "R6";
      return "R5";
    end
    if (md == 2'd0) return (rm == 3'd5) ? "R4" : "R1";
    return (md == 2'd1) ? "R2" : "R3";
  endfunction

  task automatic model(input logic [47:0] s, output int n, output logic [31:0] o, output logic bad);
    logic [1:0] md = s[7:6];
    logic [2:0] rm = s[2:0];
    int dn = 0;
    logic base_on;
    n = 1; o = 0; bad = 0;
    if (md == 2'd3) begin bad = 1; return; end
    if (rm == 3'd4) begin
      logic [1:0] sc = s[15:14];
      logic [2:0] ix = s[13:11];
      logic [2:0] bs = s[10:8];
      n = 2;
      base_on = !(md == 2'd0 && bs == 3'd5);
      if (base_on) o = regs[bs];
      if (ix != 3'd4) o = o + (regs[ix] << sc);
      else if (sc != 2'd0) bad = 1;
    end else begin
      base_on = !(md == 2'd0 && rm == 3'd5);
      if (base_on) o = regs[rm];
    end
    if (md == 2'd1) dn = 1;
    else if (md == 2'd2 || !base_on) dn = 4;
    if (dn == 1) o = o + {{24{s[8*n+7]}}, s[8*n +: 8]};
    if (dn == 4) o = o + s[8*n +: 32];
    n = n + dn;
  endtask

  task automatic run(input logic [47:0] s, input int gap);
    int n; logic [31:0] eo; logic eb; string r;
    model(s, n, eo, eb);
    r = req_of(s);
    for (int i = 0; i < n; i++) begin
      if (gap > 0 && i > 0) begin
        @(negedge clk); vld = 1'b0;
        repeat (gap - 1) @(negedge clk);
        chk("R10", "ready mid-instruction", {31'd0, rdy}, 32'd1);
        chk(r, "no early done", {31'd0, done}, 32'd0);
      end
      @(negedge clk);
      vld = 1'b1;
      dat = s[8*i +: 8];
      @(posedge clk);
    end
    @(negedge clk);
    vld = 1'b0;
    chk("R10", "done", {31'd0, done}, 32'd1);
    chk("R10", "ready low on done", {31'd0, rdy}, 32'd0);
    chk(r, "offset", off, eo);
    chk(r, "len", {29'd0, len}, n);
    chk(r, "invalid", {31'd0, inv}, {31'd0, eb});
    @(negedge clk);
    chk("R10", "done dropped", {31'd0, done}, 32'd0);
    chk("R10", "ready back", {31'd0, rdy}, 32'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 8; i++) regs[i] = 32'h1000_0000 * (i + 1) + 32'h11 * i;
    repeat (3) @(negedge clk);
    chk("R10", "reset ready", {31'd0, rdy}, 32'd1);
    chk("R10", "reset done", {31'd0, done}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    run(48'h00_0000_0000_38, 0);            // R1 eax, middle field set (ignored)
    run(48'h00_0000_0000_03, 0);            // R1 ebx
    run(48'h00_0000_0080_41, 0);            // R2 ecx + (-128)
    run(48'h00_0000_007f_47, 0);            // R2 edi + 127
    run(48'h00_1234_5678_85, 0);            // R3 ebp + disp32, LSB first
    run(48'h00_89ab_cdef_05, 0);            // R4 disp32 only
    run(48'h00_0000_00f4_04, 0);            // R5 esp base + esi<<3
    run(48'h00_0000_7f23_44, 1);            // R5/R7 no index, disp8
    run(48'h0000_0010_8d04, 0);             // R6 no base, ecx<<2 + disp32
    run(48'h00_0000_0060_04, 0);            // R7 no index with scale 1 -> invalid
    run(48'h00_0000_0000_c0, 0);            // R8 mod 3
    run(48'h00_0000_00e7_ff, 0);            // R8 mod 3, trailing byte next
    regs[0] = 32'hffff_fff0;
    run(48'h00_0000_0020_80, 0);            // R9 wrap: eax + 0x20
    regs[6] = 32'hc000_0000;
    run(48'h00_0000_00f0_04, 0);            // R9 wrap: eax + esi<<3

    for (int k = 0; k < 400; k++) begin
      logic [47:0] s;
      for (int i = 0; i < 8; i++) regs[i] = $urandom;
      s = {$urandom, $urandom};
      run(s, ($urandom % 4 == 0) ? int'($urandom % 3) + 1 : 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule